// File: doc/BRIEF.md
# Boundary-Scan Segment for Tristate Bidirectional Pins

This block is one stretch of a boundary-scan register. It covers a set of bidirectional pins, each with a tristate output driver, and it places runs of internal filler cells between groups of those pins. A test access port controller outside the block supplies the test clock, serial data and the data-register strobes: capture, shift, update and a test-mode select. The block passes functional traffic between the core and the pads. It also captures core and pad levels into its scan cells, and in test mode it drives the pads from its update latches.

Each pin owns three consecutive cells. Counting upward from the serial output, the pin has an observe-only input cell, then an output-data cell, then an output-enable control cell. A 1 in the control cell turns the driver off. Each group of pins is preceded, on the serial-output side, by a fixed number of filler cells. These filler cells have no pad and always capture 0. Shift stages move on the rising test-clock edge, and the update latches load on the falling edge. Reset leaves every driver disabled, so entering test mode before any preload cannot cause contention.

Top module: `bscan_pin_segment`

## Requirements
- R1: The chain holds exactly GRP_COUNT*(FILL_PER_GRP+3*PINS_PER_GRP) cells. Chain position 0 drives `tdo`, and `tdi` enters the highest position. On each rising `tck` edge with `shift_dr` high and `capture_dr` low, every cell takes the value of its neighbour one position further from `tdo`. A vector shifted in over exactly that many edges can therefore be shifted back out unchanged.
- R2: Group g starts at position g*(FILL_PER_GRP+3*PINS_PER_GRP) with FILL_PER_GRP filler cells. Pin k of that group is pin g*PINS_PER_GRP+k, and its input cell is at group start + FILL_PER_GRP + 3k. Its output cell is one position above the input cell, and its control cell is two positions above.
- R3: On a rising `tck` edge with `capture_dr` high, each control cell loads the pin's `core_oe`, each output cell loads `core_do`, each input cell loads `pad_di`, and each filler cell loads 0.
- R4: The update latches load from their shift stages on the falling `tck` edge while `update_dr` is high, and not before that edge.
- R5: While `extest` is 1, `pad_oe[p]` is the inverse of pin p's control latch, so a latched 1 floats the pad. In the same mode `pad_do[p]` equals pin p's output latch, and `core_oe` and `core_do` have no effect on the pads.
- R6: While `extest` is 0, `pad_oe` equals `core_oe` and `pad_do` equals `core_do`, whatever the latches hold.
- R7: `core_di` always equals `pad_di`, in both modes. The input cell has no update latch.
- R8: While `trst_n` is low, and after its synchronous release, the control latches hold 1, the output latches hold 0, the control shift stages hold 1 and all other shift stages hold 0.
- R9: Capturing or shifting without `update_dr` leaves the update latches, and therefore the test-mode pad drive, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into the highest chain position |
| shift_dr | input | 1 | Shift strobe, sampled on rising tck |
| capture_dr | input | 1 | Capture strobe, sampled on rising tck |
| update_dr | input | 1 | Update strobe, sampled on falling tck |
| extest | input | 1 | Test mode: pads driven from the update latches |
| tdo | output | 1 | Serial data from chain position 0 |
| core_do | input | NUM_PINS | Functional output data from the core |
| core_oe | input | NUM_PINS | Functional output enable from the core, 1 = drive |
| core_di | output | NUM_PINS | Pad input level returned to the core |
| pad_do | output | NUM_PINS | Data to the pad drivers |
| pad_oe | output | NUM_PINS | Enable to the pad drivers, 1 = drive |
| pad_di | input | NUM_PINS | Level received from the pads |

## Verification
The assertions assume that the controller never raises capture and shift in the same cycle. They also assume that update is raised only outside a shift, and that every strobe changes away from both clock edges. The bench keeps to these assumptions by driving all inputs one nanosecond after a rising edge and by pulsing each strobe alone. The update pulse covers exactly one falling edge, and the bench reads the pads on each side of that edge.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  typedef enum logic [1:0] {
    CELL_FILL = 2'd0,
    CELL_IN   = 2'd1,
    CELL_OUT  = 2'd2,
    CELL_CTL  = 2'd3
  } cell_kind_e;

  // Returns the kind of cell at a chain position (0 = nearest tdo).
  function automatic cell_kind_e kind_at(input int pos, input int pins_per_grp,
                                         input int fill_per_grp);
    int grp_len;
    int off;
    grp_len = fill_per_grp + 3 * pins_per_grp;
    off     = pos % grp_len;
    if (off < fill_per_grp) return CELL_FILL;
    case ((off - fill_per_grp) % 3)
      0:       return CELL_IN;
      1:       return CELL_OUT;
      default: return CELL_CTL;
    endcase
  endfunction

  // Returns the pin served by a non-filler chain position.
  function automatic int pin_at(input int pos, input int pins_per_grp,
                                input int fill_per_grp);
    int grp_len;
    int off;
    grp_len = fill_per_grp + 3 * pins_per_grp;
    off     = pos % grp_len;
    return (pos / grp_len) * pins_per_grp + (off - fill_per_grp) / 3;
  endfunction

endpackage

// File: rtl/bsp_reset_sync.sv
module bsp_reset_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n = sync_q[1];
endmodule

// File: rtl/bsp_chain_stage.sv
module bsp_chain_stage #(
  parameter bsp_pkg::cell_kind_e KIND = bsp_pkg::CELL_FILL
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic capture_en,
  input  logic shift_in,
  input  logic cap_val,
  output logic q
);
  localparam logic RST_VAL = (KIND == bsp_pkg::CELL_CTL) ? 1'b1 : 1'b0;

  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (capture_en)    q_nxt = cap_val;
    else if (shift_en) q_nxt = shift_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end

  // R1: a shift moves the neighbour value in one position per rising edge
  a_r1_shift_step: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !capture_en) |=> (q == $past(shift_in)));

  // R3: a capture loads the cell's capture source
  a_r3_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (q == $past(cap_val)));

  generate
    if (KIND == bsp_pkg::CELL_FILL) begin : g_fill_chk
      // R3: filler cells always capture their safe value 0
      a_r3_filler_zero: assert property (@(posedge clk) disable iff (!rst_n)
        capture_en |=> (q == 1'b0));
    end
  endgenerate
endmodule

// File: rtl/bsp_update_latch.sv
module bsp_update_latch #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_en,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (upd_en) q_nxt = d;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end

  // R4: an update on the falling edge copies the shift stage
  a_r4_update_copy: assert property (@(negedge clk) disable iff (!rst_n)
    upd_en |=> (q == $past(d)));

  // R9: without an update strobe the latch holds
  a_r9_latch_hold: assert property (@(negedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(q));
endmodule

// File: rtl/bscan_pin_segment.sv
module bscan_pin_segment #(
  parameter int PINS_PER_GRP = 2,
  parameter int GRP_COUNT    = 2,
  parameter int FILL_PER_GRP = 2,
  localparam int NUM_PINS    = PINS_PER_GRP * GRP_COUNT,
  localparam int GRP_LEN     = FILL_PER_GRP + 3 * PINS_PER_GRP,
  localparam int CHAIN_LEN   = GRP_COUNT * GRP_LEN
) (
  input  logic                tck,
  input  logic                trst_n,
  input  logic                tdi,
  input  logic                shift_dr,
  input  logic                capture_dr,
  input  logic                update_dr,
  input  logic                extest,
  output logic                tdo,
  input  logic [NUM_PINS-1:0] core_do,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] core_di,
  output logic [NUM_PINS-1:0] pad_do,
  output logic [NUM_PINS-1:0] pad_oe,
  input  logic [NUM_PINS-1:0] pad_di
);
  logic                 rst_n;
  logic [CHAIN_LEN-1:0] sr_q;
  logic [CHAIN_LEN-1:0] sr_src;
  logic [CHAIN_LEN-1:0] cap_src;
  logic [NUM_PINS-1:0]  ctl_lat;
  logic [NUM_PINS-1:0]  out_lat;

  bsp_reset_sync u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n)
  );

  // Serial path: tdi enters the top, every other cell takes its upper neighbour.
  assign sr_src = {tdi, sr_q[CHAIN_LEN-1:1]};
  assign tdo    = sr_q[0];

  genvar gi;
  generate
    for (gi = 0; gi < CHAIN_LEN; gi++) begin : g_cell
      localparam bsp_pkg::cell_kind_e KIND =
        bsp_pkg::kind_at(gi, PINS_PER_GRP, FILL_PER_GRP);

      if (KIND == bsp_pkg::CELL_FILL) begin : g_fill
        assign cap_src[gi] = 1'b0;
      end else begin : g_pin
        localparam int PIN = bsp_pkg::pin_at(gi, PINS_PER_GRP, FILL_PER_GRP);
        if (KIND == bsp_pkg::CELL_IN) begin : g_in
          assign cap_src[gi] = pad_di[PIN];
        end else if (KIND == bsp_pkg::CELL_OUT) begin : g_out
          assign cap_src[gi] = core_do[PIN];
        end else begin : g_ctl
          assign cap_src[gi] = core_oe[PIN];
        end
      end

      bsp_chain_stage #(.KIND(KIND)) u_stage (
        .clk        (tck),
        .rst_n      (rst_n),
        .shift_en   (shift_dr),
        .capture_en (capture_dr),
        .shift_in   (sr_src[gi]),
        .cap_val    (cap_src[gi]),
        .q          (sr_q[gi])
      );
    end

    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin_upd
      localparam int BASE = (gi / PINS_PER_GRP) * GRP_LEN + FILL_PER_GRP
                          + 3 * (gi % PINS_PER_GRP);

      bsp_update_latch #(.RST_VAL(1'b1)) u_ctl_lat (
        .clk    (tck),
        .rst_n  (rst_n),
        .upd_en (update_dr),
        .d      (sr_q[BASE+2]),
        .q      (ctl_lat[gi])
      );

      bsp_update_latch #(.RST_VAL(1'b0)) u_out_lat (
        .clk    (tck),
        .rst_n  (rst_n),
        .upd_en (update_dr),
        .d      (sr_q[BASE+1]),
        .q      (out_lat[gi])
      );
    end
  endgenerate

  // Pad selection: test mode drives from latches, control 1 disables.
  always_comb begin
    if (extest) begin
      pad_oe = ~ctl_lat;
      pad_do = out_lat;
    end else begin
      pad_oe = core_oe;
      pad_do = core_do;
    end
  end

  assign core_di = pad_di;

  // R5: in test mode, with no update at the previous fall, the pad drive holds
  a_r5_extest_hold: assert property (@(posedge tck) disable iff (!rst_n)
    (extest && $past(extest) && !$past(update_dr) && !update_dr)
      |-> ($stable(pad_oe) && $stable(pad_do)));
endmodule

// File: tb/bscan_pin_segment_tb.sv
module bscan_pin_segment_tb;
  localparam int P = 2, G = 2, F = 2;
  localparam int N = P * G;
  localparam int GL = F + 3 * P;
  localparam int L = G * GL;

  logic tck, trst_n, tdi, shift_dr, capture_dr, update_dr, extest;
  logic tdo;
  logic [N-1:0] core_do, core_oe, core_di, pad_do, pad_oe, pad_di;

  int total = 0;
  int bad = 0;

  bscan_pin_segment #(.PINS_PER_GRP(P), .GRP_COUNT(G), .FILL_PER_GRP(F)) u_dut (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .shift_dr(shift_dr),
    .capture_dr(capture_dr), .update_dr(update_dr), .extest(extest),
    .tdo(tdo), .core_do(core_do), .core_oe(core_oe), .core_di(core_di),
    .pad_do(pad_do), .pad_oe(pad_oe), .pad_di(pad_di)
  );

  initial tck = 1'b0;
  always #2 tck = ~tck;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    #1;
  endtask

  function automatic int in_pos(input int p);
    return (p / P) * GL + F + 3 * (p % P);
  endfunction

  // Expected capture image computed from the chain layout.
  function automatic logic [L-1:0] cap_image(input logic [N-1:0] oe,
                                             input logic [N-1:0] dout,
                                             input logic [N-1:0] din);
    logic [L-1:0] v = '0;
    for (int p = 0; p < N; p++) begin
      v[in_pos(p)]     = din[p];
      v[in_pos(p) + 1] = dout[p];
      v[in_pos(p) + 2] = oe[p];
    end
    return v;
  endfunction

  // Shifts L bits: vin[i] ends at position i, vout[i] was at position i.
  task automatic xfer(input logic [L-1:0] vin, output logic [L-1:0] vout);
    shift_dr = 1'b1;
    for (int i = 0; i < L; i++) begin
      vout[i] = tdo;
      tdi = vin[i];
      tick();
    end
    shift_dr = 1'b0;
  endtask

  task automatic capture();
    capture_dr = 1'b1;
    tick();
    capture_dr = 1'b0;
  endtask

  task automatic update();
    update_dr = 1'b1;
    tick();
    update_dr = 1'b0;
  endtask

  task automatic run();
    logic [L-1:0] got, vin;
    logic [N-1:0] e_oe, e_do;
    trst_n = 1'b0; tdi = 0; shift_dr = 0; capture_dr = 0; update_dr = 0;
    extest = 0; core_do = '0; core_oe = '1; pad_di = '0;
    repeat (3) tick();
    // R8: state while held in reset
    extest = 1'b1; #0.5;
    check(pad_oe == '0, "R8 reset oe", pad_oe, 0);
    check(pad_do == '0, "R8 reset do", pad_do, 0);
    check(tdo == 1'b0, "R8 reset tdo", tdo, 0);
    trst_n = 1'b1;
    repeat (3) tick();
    check(pad_oe == '0, "R8 post-release oe", pad_oe, 0);
    // R8: shift stages hold safe values (control 1, others 0)
    extest = 1'b0;
    xfer('0, got);
    check(got == cap_image('1, '0, '0), "R8 safe shift stages", got, cap_image('1, '0, '0));

    // R6: transparent in functional mode, sweep all enables and data
    for (int a = 0; a < (1 << N); a++)
      for (int b = 0; b < (1 << N); b++) begin
        core_oe = N'(a); core_do = N'(b); #0.5;
        check(pad_oe == core_oe && pad_do == core_do, "R6 transparent",
              {pad_oe, pad_do}, {core_oe, core_do});
      end

    // R7: core input follows the pad in both modes
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << N); a++) begin
        extest = m[0]; pad_di = N'(a); #0.5;
        check(core_di == pad_di, "R7 input passthrough", core_di, pad_di);
      end
    extest = 1'b0;

    // R2 R3: capture image over several patterns
    for (int a = 0; a < (1 << N); a++) begin
      core_oe = N'(a); core_do = N'(a * 5 + 3); pad_di = N'(a ^ 6);
      capture();
      xfer('0, got);
      check(got == cap_image(core_oe, core_do, pad_di), "R3 R2 capture image",
            got, cap_image(core_oe, core_do, pad_di));
    end

    // R5 R1 R9: preload then test-mode drive
    for (int c = 0; c < (1 << N); c++) begin
      vin = cap_image(N'(c), N'(c * 3 + 1), N'(c + 9));
      for (int g = 0; g < G; g++) vin[g * GL] = 1'b1;  // filler bits carry data too
      xfer(vin, got);
      update();
      extest = 1'b1;
      core_oe = N'(~c); core_do = N'(c + 2); #0.5;
      e_oe = ~N'(c); e_do = N'(c * 3 + 1);
      check(pad_oe == e_oe, "R5 extest enable", pad_oe, e_oe);
      check(pad_do == e_do, "R5 extest data", pad_do, e_do);
      capture();
      xfer(~vin, got);
      check(pad_oe == e_oe && pad_do == e_do, "R9 hold through capture and shift",
            {pad_oe, pad_do}, {e_oe, e_do});
      extest = 1'b0;
      xfer(vin, got);
      check(got == ~vin, "R1 round trip length", got, ~vin);
    end

    // R4: latches change on the falling edge only
    vin = cap_image('0, '1, '0);
    xfer(vin, got);
    update_dr = 1'b1;
    extest = 1'b1; #0.5;
    check(pad_oe == '0, "R4 before fall", pad_oe, 0);
    @(negedge tck); #0.5;
    check(pad_oe == '1 && pad_do == '1, "R4 after fall", {pad_oe, pad_do}, {N'('1), N'('1)});
    @(posedge tck); #1;
    update_dr = 1'b0;
    extest = 1'b0;
  endtask

  initial begin
    fork
      run();
      begin
        repeat (200000) @(posedge tck);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule